// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block walks the column addresses of one synchronous DRAM burst. It watches the command bus. When a read or write command is issued, it captures the start column, the burst length code and the burst type. From the next clock on, it presents one column address per cycle together with a valid strobe and a write flag.

A sequential burst counts up inside an aligned window whose size is the burst length. An interleaved burst flips the low address bits in a fixed order. A full-page burst runs through all 512 columns, wrapping round, until it is stopped. A burst-stop command ends any burst at once, so no further write beats are taken. A new read or write command replaces the running burst.

For reads the block also drives the data-bus output enable. It holds the enable for a CAS-latency number of cycles after the last column beat, so the final data words can leave before the bus is released.

Top module: `sdram_col_seq`

## Requirements
- R1: Commands are sampled at the rising clock edge as {cs_n,ras_n,cas_n,we_n}: 0101 is read, 0100 is write, 0110 is burst stop. Any pattern with cs_n high is ignored, including 1110.
- R2: A read or write sampled at an edge gives col_valid=1 and col_addr=start_col in the following cycle. col_write is 1 for a write and 0 for a read.
- R3: bl_code selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4, 5 and 6 give 1 beat. col_valid falls in the cycle after the last beat.
- R4: With burst_il=0, the low log2(N) column bits of beat k equal (start + k) mod N, with no carry into higher bits.
- R5: With burst_il=1 and N of 2, 4 or 8, the low log2(N) bits of beat k equal the start's low bits XOR k.
- R6: Column bits above the varying low bits keep the start value for the whole burst.
- R7: A full-page burst increments all 9 column bits modulo 512 for either burst type. It runs until a burst stop or a new command arrives.
- R8: A burst stop sampled at an edge forces col_valid low from the next cycle. No later beat of the stopped burst, read or write, is presented.
- R9: A read or write sampled during a burst restarts at the new start column in the next cycle.
- R10: dq_oe is 1 in every beat cycle of a read. It stays 1 for exactly L further cycles after the read's last beat cycle, where L is 2 when cas_lat=2 and 3 for any other value. It is 0 during write bursts that follow idle time.
- R11: bl_code, burst_il and start_col are taken only with a read or write command. Changing them during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| start_col | input | 9 | Start column supplied with a read or write |
| bl_code | input | 3 | Burst length code |
| burst_il | input | 1 | 0 sequential, 1 interleaved |
| cas_lat | input | 2 | CAS latency select (2, otherwise 3) |
| col_addr | output | 9 | Column address of the current beat |
| col_valid | output | 1 | Current beat is valid |
| col_write | output | 1 | Current burst is a write |
| dq_oe | output | 1 | Data bus output enable for reads |

## Verification
A corrupted beat counter or window mask shows at once on col_addr. Upper bits move, or low bits leave the expected order, within the same cycle the bad state exists. A wrong end-of-burst or stop decision shows one cycle after the deciding edge, as col_valid staying high or dropping early. A fault in the output-enable hold counter appears only after a read ends, as dq_oe releasing one or more cycles away from the latency window.

// File: rtl/sdram_col_seq_pkg.sv
package sdram_col_seq_pkg;

    localparam int COL_W  = 9;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE,
        CMD_STOP
    } cmd_e;

    typedef struct packed {
        logic             active;
        logic             wr;
        logic             il;
        logic             full;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
    } burst_t;

    localparam logic [CODE_W-1:0] CODE_FULL = 3'd7;

    function automatic logic [COL_W-1:0] window_mask(input logic [CODE_W-1:0] code);
        logic [COL_W-1:0] m;
        case (code)
            3'd1:    m = COL_W'(1);
            3'd2:    m = COL_W'(3);
            3'd3:    m = COL_W'(7);
            3'd7:    m = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_col_seq_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (!cs_n && ras_n) begin
            case ({cas_n, we_n})
                2'b01:   cmd = CMD_READ;
                2'b00:   cmd = CMD_WRITE;
                2'b10:   cmd = CMD_STOP;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
    import sdram_col_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] bl_code,
    input  logic              burst_il,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_write
);

    burst_t st, nx;
    logic   is_load;
    logic [COL_W-1:0] low_part;

    assign is_load = (cmd == CMD_READ) || (cmd == CMD_WRITE);

    always_comb begin
        nx = st;
        if (is_load) begin
            nx.active = 1'b1;
            nx.wr     = (cmd == CMD_WRITE);
            nx.base   = start_col;
            nx.beat   = '0;
            nx.mask   = window_mask(bl_code);
            nx.full   = (bl_code == CODE_FULL);
            nx.il     = burst_il && (bl_code != CODE_FULL);
        end else if (cmd == CMD_STOP) begin
            nx.active = 1'b0;
        end else if (st.active) begin
            if (!st.full && (st.beat == st.mask))
                nx.active = 1'b0;
            else
                nx.beat = st.beat + COL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    assign low_part  = st.il ? (st.base ^ st.beat) : (st.base + st.beat);
    assign col_addr  = (st.base & ~st.mask) | (low_part & st.mask);
    assign col_valid = st.active;
    assign col_write = st.wr;

    // R8
    stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STOP) |=> !col_valid);

    // R2
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        is_load |=> (col_valid && col_addr == $past(start_col)));

    // R6
    high_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (col_valid && $past(col_valid) && $past(cmd) == CMD_NONE)
        |-> (((col_addr ^ $past(col_addr)) & ~st.mask) == '0));

    // R4
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (col_valid && $past(col_valid) && $past(cmd) == CMD_NONE && !st.il)
        |-> ((col_addr & st.mask) == (($past(col_addr) + COL_W'(1)) & st.mask)));

endmodule

// File: rtl/sdram_oe_hold.sv
module sdram_oe_hold #(
    parameter int HOLD_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_active,
    input  logic [1:0] cas_lat,
    output logic       dq_oe
);

    logic [HOLD_W-1:0] hold;
    logic [HOLD_W-1:0] lat_val;

    assign lat_val = (cas_lat == 2'd2) ? HOLD_W'(2) : HOLD_W'(3);

    always_ff @(posedge clk) begin
        if (rst)                    hold <= '0;
        else if (rd_active)         hold <= lat_val;
        else if (hold != '0)        hold <= hold - HOLD_W'(1);
    end

    assign dq_oe = rd_active || (hold != '0);

    // R10
    end_keeps_oe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_active) |-> dq_oe);

    // R10
    oe_rise_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> rd_active);

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdram_col_seq_pkg::*;
#(
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] bl_code,
    input  logic              burst_il,
    input  logic [1:0]        cas_lat,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_write,
    output logic              dq_oe
);

    cmd_e cmd;
    logic rd_active;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_col_gen u_gen (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .start_col (start_col),
        .bl_code   (bl_code),
        .burst_il  (burst_il),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_write (col_write)
    );

    assign rd_active = col_valid && !col_write;

    sdram_oe_hold #(.HOLD_W(HOLD_W)) u_oe (
        .clk       (clk),
        .rst       (rst),
        .rd_active (rd_active),
        .cas_lat   (cas_lat),
        .dq_oe     (dq_oe)
    );

endmodule

// File: tb/sdram_col_seq_tb.sv
`timescale 1ns/1ps
module sdram_col_seq_tb_top;

    localparam logic [3:0] C_READ  = 4'b0101;
    localparam logic [3:0] C_WRITE = 4'b0100;
    localparam logic [3:0] C_STOP  = 4'b0110;
    localparam logic [3:0] C_NOP   = 4'b0111;
    localparam logic [3:0] C_DESWE = 4'b1110;

    typedef struct packed {
        logic            il;
        logic [2:0]      blc;
        logic [8:0]      start;
        logic [3:0]      n;
        logic [7:0][8:0] seq;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 3'd2, 9'h0A5, 4'd4, {9'h0, 9'h0, 9'h0, 9'h0, 9'h0A4, 9'h0A7, 9'h0A6, 9'h0A5}},
        '{1'b1, 3'd2, 9'h0A5, 4'd4, {9'h0, 9'h0, 9'h0, 9'h0, 9'h0A6, 9'h0A7, 9'h0A4, 9'h0A5}},
        '{1'b0, 3'd3, 9'h1FD, 4'd8, {9'h1FC, 9'h1FB, 9'h1FA, 9'h1F9, 9'h1F8, 9'h1FF, 9'h1FE, 9'h1FD}},
        '{1'b1, 3'd3, 9'h1FD, 4'd8, {9'h1FA, 9'h1FB, 9'h1F8, 9'h1F9, 9'h1FE, 9'h1FF, 9'h1FC, 9'h1FD}},
        '{1'b0, 3'd1, 9'h013, 4'd2, {9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h012, 9'h013}},
        '{1'b1, 3'd1, 9'h012, 4'd2, {9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h013, 9'h012}},
        '{1'b0, 3'd0, 9'h155, 4'd1, {9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h155}},
        '{1'b1, 3'd5, 9'h0C3, 4'd1, {9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0C3}}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] cmdv;
    logic [8:0] start_col;
    logic [2:0] bl_code;
    logic       burst_il;
    logic [1:0] cas_lat;
    logic [8:0] col_addr;
    logic       col_valid, col_write, dq_oe;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    sdram_col_seq dut_i (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cmdv[3]),
        .ras_n     (cmdv[2]),
        .cas_n     (cmdv[1]),
        .we_n      (cmdv[0]),
        .start_col (start_col),
        .bl_code   (bl_code),
        .burst_il  (burst_il),
        .cas_lat   (cas_lat),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_write (col_write),
        .dq_oe     (dq_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [8:0] s,
                         input logic [2:0] b, input logic il);
        cmdv = c; start_col = s; bl_code = b; burst_il = il;
    endtask

    task automatic settle();
        cmdv = C_NOP;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; cmdv = C_NOP; start_col = '0; bl_code = '0;
        burst_il = 1'b0; cas_lat = 2'd2;
        repeat (3) @(negedge clk);
        chk("R2 reset valid", col_valid, 0);
        chk("R10 reset oe", dq_oe, 0);
        rst = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R11
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            issue(C_READ, VECS[v].start, VECS[v].blc, VECS[v].il);
            @(negedge clk);
            cmdv = C_NOP; bl_code = 3'd7; burst_il = ~VECS[v].il; start_col = 9'h000;
            for (int b = 0; b < int'(VECS[v].n); b++) begin
                chk("R3 beat valid", col_valid, 1);
                chk("R4/R5/R6/R11 beat addr", col_addr, VECS[v].seq[b]);
                @(negedge clk);
            end
            chk("R3 burst end", col_valid, 0);
            settle();
        end

        // Full-page write, deselected pattern ignored, stop: R7 R1 R8
        @(negedge clk);
        issue(C_WRITE, 9'h1FE, 3'd7, 1'b0);
        @(negedge clk);
        cmdv = C_NOP;
        chk("R2 write flag", col_write, 1);
        chk("R7 addr 1FE", col_addr, 9'h1FE);
        @(negedge clk);
        cmdv = C_DESWE;
        chk("R7 addr 1FF", col_addr, 9'h1FF);
        @(negedge clk);
        cmdv = C_NOP;
        chk("R1 deselect ignored", col_valid, 1);
        chk("R7 wrap 000", col_addr, 9'h000);
        chk("R10 no oe on write", dq_oe, 0);
        @(negedge clk);
        cmdv = C_STOP;
        chk("R7 addr 001", col_addr, 9'h001);
        @(negedge clk);
        cmdv = C_NOP;
        chk("R8 write stopped", col_valid, 0);
        @(negedge clk);
        chk("R8 stays stopped", col_valid, 0);
        settle();

        // Full-page read with interleave flag, stop, CL3: R7 R8 R10
        cas_lat = 2'd3;
        @(negedge clk);
        issue(C_READ, 9'h0FF, 3'd7, 1'b1);
        @(negedge clk);
        cmdv = C_NOP;
        chk("R7 addr 0FF", col_addr, 9'h0FF);
        chk("R10 oe in read", dq_oe, 1);
        @(negedge clk);
        cmdv = C_STOP;
        chk("R7 carry 100", col_addr, 9'h100);
        @(negedge clk);
        cmdv = C_NOP;
        chk("R8 read stopped", col_valid, 0);
        chk("R10 hold 1 cl3", dq_oe, 1);
        @(negedge clk);
        chk("R10 hold 2 cl3", dq_oe, 1);
        @(negedge clk);
        chk("R10 hold 3 cl3", dq_oe, 1);
        @(negedge clk);
        chk("R10 release cl3", dq_oe, 0);
        settle();

        // Natural end, CL2: R10
        cas_lat = 2'd2;
        @(negedge clk);
        issue(C_READ, 9'h040, 3'd1, 1'b0);
        @(negedge clk);
        cmdv = C_NOP;
        chk("R10 oe beat0", dq_oe, 1);
        @(negedge clk);
        chk("R4 addr 041", col_addr, 9'h041);
        @(negedge clk);
        chk("R3 end bl2", col_valid, 0);
        chk("R10 hold 1 cl2", dq_oe, 1);
        @(negedge clk);
        chk("R10 hold 2 cl2", dq_oe, 1);
        @(negedge clk);
        chk("R10 release cl2", dq_oe, 0);
        settle();

        // Restart mid-burst: R9
        @(negedge clk);
        issue(C_READ, 9'h010, 3'd3, 1'b0);
        @(negedge clk);
        cmdv = C_NOP;
        chk("R9 first 010", col_addr, 9'h010);
        @(negedge clk);
        issue(C_WRITE, 9'h100, 3'd1, 1'b0);
        chk("R9 second 011", col_addr, 9'h011);
        @(negedge clk);
        cmdv = C_NOP;
        chk("R9 restart addr", col_addr, 9'h100);
        chk("R9 restart write", col_write, 1);
        @(negedge clk);
        chk("R9 next 101", col_addr, 9'h101);
        @(negedge clk);
        chk("R9 end", col_valid, 0);
        settle();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule